// File: doc/BRIEF.md
# Masked Interrupt Status Register Group

This block collects hardware event pulses into sticky status bits and raises one level interrupt line while any pending bit is not masked. Software reaches it through a plain 32-bit word register port. It reads the status, clears bits by writing ones to them, and changes the mask only through two command addresses. One command address unmasks sources and the other masks them. The mask itself cannot be written directly.

The number of event sources is a parameter, one by default. Every source starts masked after reset. The interrupt output is a registered level. It follows the pending state of the previous cycle, so a status clear, a mask command or a reset shows on the line one clock after it takes effect.

Word offsets are fixed as follows: status at byte offset 0x0, mask at 0x4, unmask command at 0x8 and mask command at 0xC. Event source i maps to bit i at every offset.

Top module: `irq_status_group`

## Requirements
- R1: Reset is asynchronous and active low. After reset the status reads 0, the mask reads all ones over the source bits (0x1 for one source) and irqOut is low.
- R2: A high evtIn bit at a clock edge sets its status bit. The bit stays set after the event input falls and is only cleared by software.
- R3: A write to offset 0x0 clears each status bit whose data bit is 1. Status bits whose data bit is 0 are left unchanged.
- R4: When an event and a clearing write to the same status bit meet at one edge, the event wins and the bit ends up set.
- R5: A write to the mask offset 0x4 changes nothing. The mask changes only through the command offsets.
- R6: A write to offset 0x8 clears each mask bit whose data bit is 1.
- R7: A write to offset 0xC sets each mask bit whose data bit is 1.
- R8: Reads of offsets 0x8 and 0xC always return 0.
- R9: irqOut is high in a cycle exactly when, in the previous cycle, some status bit was 1 and its mask bit was 0.
- R10: A write is accepted only if busByteEn is 4'hF and busAddr[1:0] is 0. Any other write changes neither status nor mask.
- R11: busRdData carries the addressed word in the cycle after busRdEn is high. It is 0 in any cycle that does not follow a read, and 0 after a read with busAddr[1:0] other than 0. Status and mask bits above the source count read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| evtIn | input | NUM_EVT | Event inputs; a high level sets the matching status bit |
| busWrEn | input | 1 | Write strobe |
| busRdEn | input | 1 | Read strobe |
| busAddr | input | ADDR_W | Byte address of the access |
| busWrData | input | 32 | Write data |
| busByteEn | input | 4 | Byte lanes; a write needs all four |
| busRdData | output | 32 | Read data, valid in the cycle after busRdEn |
| irqOut | output | 1 | Registered level interrupt |

## Verification
The bench targets the edge where an event and a clearing write meet. A design that let the clear win would lose an interrupt, and the status read would return 0. It writes the mask address directly and issues partial-lane and misaligned writes. A design that took any of these would show a changed mask or a cleared status on read-back. It watches irqOut on every clock against a model that delays the pending term by one cycle. An output driven combinationally, or delayed by two cycles, mismatches on the edges around each unmask, mask and clear.

// File: rtl/irq_status_pkg.sv
package irq_status_pkg;

  // word offsets, decoded from busAddr[3:2]
  typedef enum logic [1:0] {
    SEL_STATUS = 2'd0,
    SEL_MASK   = 2'd1,
    SEL_UNMASK = 2'd2,
    SEL_DOMASK = 2'd3
  } regSelT;

  // strobes from control to datapath
  typedef struct packed {
    logic   clrStat;   // write-one-to-clear on status
    logic   clrMask;   // unmask command
    logic   setMask;   // mask command
    logic   rdStrobe;  // capture read data this edge
    regSelT rdSel;     // which word to capture
  } cmdT;

endpackage

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl
  import irq_status_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [3:0]        busByteEn,
  output cmdT               cmd
);

  logic   inWindow;
  logic   aligned;
  logic   wrAccept;
  regSelT sel;

  generate
    if (ADDR_W > 4) begin : g_hiDecode
      assign inWindow = (busAddr[ADDR_W-1:4] == '0);
    end else begin : g_noHi
      assign inWindow = 1'b1;
    end
  endgenerate

  assign aligned  = (busAddr[1:0] == 2'b00);
  assign sel      = regSelT'(busAddr[3:2]);
  assign wrAccept = busWrEn && aligned && inWindow && (busByteEn == 4'hF);

  always_comb begin
    cmd          = '0;
    cmd.rdSel    = sel;
    cmd.rdStrobe = busRdEn && aligned && inWindow;
    if (wrAccept) begin
      unique case (sel)
        SEL_STATUS: cmd.clrStat = 1'b1;
        SEL_UNMASK: cmd.clrMask = 1'b1;
        SEL_DOMASK: cmd.setMask = 1'b1;
        default:    ;  // mask word is read-only
      endcase
    end
  end

endmodule

// File: rtl/irq_status_dp.sv
module irq_status_dp
  import irq_status_pkg::*;
#(
  parameter int NUM_EVT = 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  cmdT                cmd,
  input  logic [NUM_EVT-1:0] evtIn,
  input  logic [NUM_EVT-1:0] wrBits,
  output logic [NUM_EVT-1:0] statusQ,
  output logic [NUM_EVT-1:0] maskQ,
  output logic               irqQ,
  output logic [31:0]        rdDataQ
);

  logic [NUM_EVT-1:0] statusD;
  logic [NUM_EVT-1:0] maskD;
  logic [31:0]        rdWord;

  // event applied after the clear so that it wins
  always_comb begin
    statusD = statusQ;
    if (cmd.clrStat) statusD = statusD & ~wrBits;
    statusD = statusD | evtIn;
  end

  always_comb begin
    maskD = maskQ;
    if (cmd.clrMask) maskD = maskD & ~wrBits;
    if (cmd.setMask) maskD = maskD | wrBits;
  end

  always_comb begin
    rdWord = '0;
    unique case (cmd.rdSel)
      SEL_STATUS: rdWord[NUM_EVT-1:0] = statusQ;
      SEL_MASK:   rdWord[NUM_EVT-1:0] = maskQ;
      default:    rdWord = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statusQ <= '0;
      maskQ   <= '1;
      irqQ    <= 1'b0;
      rdDataQ <= '0;
    end else begin
      statusQ <= statusD;
      maskQ   <= maskD;
      irqQ    <= |(statusQ & ~maskQ);
      rdDataQ <= cmd.rdStrobe ? rdWord : 32'd0;
    end
  end

endmodule

// File: rtl/irq_status_group.sv
module irq_status_group
  import irq_status_pkg::*;
#(
  parameter int NUM_EVT = 1,
  parameter int ADDR_W  = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_EVT-1:0] evtIn,
  input  logic               busWrEn,
  input  logic               busRdEn,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [31:0]        busWrData,
  input  logic [3:0]         busByteEn,
  output logic [31:0]        busRdData,
  output logic               irqOut
);

  cmdT                cmd;
  logic [NUM_EVT-1:0] statusQ;
  logic [NUM_EVT-1:0] maskQ;
  logic               cmdClrStat;
  logic               cmdClrMask;
  logic               cmdSetMask;
  logic               unusedWrBits;

  assign unusedWrBits = &{1'b0, busWrData};

  irq_status_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .busWrEn   (busWrEn),
    .busRdEn   (busRdEn),
    .busAddr   (busAddr),
    .busByteEn (busByteEn),
    .cmd       (cmd)
  );

  irq_status_dp #(.NUM_EVT(NUM_EVT)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .cmd     (cmd),
    .evtIn   (evtIn),
    .wrBits  (busWrData[NUM_EVT-1:0]),
    .statusQ (statusQ),
    .maskQ   (maskQ),
    .irqQ    (irqOut),
    .rdDataQ (busRdData)
  );

  assign cmdClrStat = cmd.clrStat;
  assign cmdClrMask = cmd.clrMask;
  assign cmdSetMask = cmd.setMask;

endmodule

// File: rtl/irq_status_checker.sv
module irq_status_checker #(
  parameter int NUM_EVT = 1,
  parameter int ADDR_W  = 4
) (
  input logic               clk,
  input logic               rstN,
  input logic [NUM_EVT-1:0] evtIn,
  input logic               busWrEn,
  input logic [ADDR_W-1:0]  busAddr,
  input logic [3:0]         busByteEn,
  input logic               irqOut,
  input logic [NUM_EVT-1:0] statusQ,
  input logic [NUM_EVT-1:0] maskQ,
  input logic               cmdClrStat,
  input logic               cmdClrMask,
  input logic               cmdSetMask
);

  // R2: without a clearing write no status bit may fall
  a_r2_sticky: assert property (@(posedge clk) disable iff (!rstN)
    !cmdClrStat |=> ((~statusQ & $past(statusQ)) == '0));

  // R4: every event bit is set after the edge, clear or not
  a_r4_event_wins: assert property (@(posedge clk) disable iff (!rstN)
    (evtIn != '0) |=> ((statusQ & $past(evtIn)) == $past(evtIn)));

  // R5: the mask moves only on a command
  a_r5_mask_cmd_only: assert property (@(posedge clk) disable iff (!rstN)
    !(cmdClrMask || cmdSetMask) |=> $stable(maskQ));

  // R9: the output tracks the pending term one cycle late
  a_r9_irq_delayed: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (irqOut == (|($past(statusQ) & ~$past(maskQ)))));

  // R10: a partial or misaligned write changes nothing
  a_r10_reject_partial: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && ((busByteEn != 4'hF) || (busAddr[1:0] != 2'b00)))
      |=> ($stable(maskQ) && ((~statusQ & $past(statusQ)) == '0)));

endmodule

bind irq_status_group irq_status_checker #(.NUM_EVT(NUM_EVT), .ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .evtIn      (evtIn),
  .busWrEn    (busWrEn),
  .busAddr    (busAddr),
  .busByteEn  (busByteEn),
  .irqOut     (irqOut),
  .statusQ    (statusQ),
  .maskQ      (maskQ),
  .cmdClrStat (cmdClrStat),
  .cmdClrMask (cmdClrMask),
  .cmdSetMask (cmdSetMask)
);

// File: tb/sim_irq_status_group.sv
`timescale 1ns/1ps
module sim_irq_status_group;

  localparam int NEV = 1;
  localparam int AW  = 4;

  logic           clk = 1'b0;
  logic           rstN = 1'b0;
  logic [NEV-1:0] evtIn = '0;
  logic           busWrEn = 1'b0;
  logic           busRdEn = 1'b0;
  logic [AW-1:0]  busAddr = '0;
  logic [31:0]    busWrData = '0;
  logic [3:0]     busByteEn = 4'hF;
  logic [31:0]    busRdData;
  logic           irqOut;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  irq_status_group #(.NUM_EVT(NEV), .ADDR_W(AW)) u0 (
    .clk(clk), .rstN(rstN), .evtIn(evtIn), .busWrEn(busWrEn),
    .busRdEn(busRdEn), .busAddr(busAddr), .busWrData(busWrData),
    .busByteEn(busByteEn), .busRdData(busRdData), .irqOut(irqOut)
  );

  // behavioural reference model
  logic [NEV-1:0] mStat;
  logic [NEV-1:0] mMask;
  logic           mIrq;
  logic [31:0]    mRd;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mStat = '0; mMask = '1; mIrq = 1'b0; mRd = '0;
    end else begin
      logic ok;
      logic [31:0] w;
      ok   = busWrEn && (busByteEn == 4'hF) && (busAddr[1:0] == 2'b00);
      mIrq = |(mStat & ~mMask);
      w = '0;
      if (busRdEn && busAddr[1:0] == 2'b00) begin
        if (busAddr[3:2] == 2'd0) w[NEV-1:0] = mStat;
        if (busAddr[3:2] == 2'd1) w[NEV-1:0] = mMask;
      end
      mRd = w;
      if (ok && busAddr[3:2] == 2'd0) mStat = mStat & ~busWrData[NEV-1:0];
      mStat = mStat | evtIn;
      if (ok && busAddr[3:2] == 2'd2) mMask = mMask & ~busWrData[NEV-1:0];
      if (ok && busAddr[3:2] == 2'd3) mMask = mMask | busWrData[NEV-1:0];
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h at %0t", tag, act, exp, $time);
    end
  endtask

  // every-clock comparison, R9 and R11
  always @(negedge clk) begin
    if (rstN && !done) begin
      check("R9 irq vs model", {31'd0, irqOut}, {31'd0, mIrq});
      check("R11 rdData vs model", busRdData, mRd);
    end
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d, input logic [3:0] be);
    busWrEn = 1'b1; busAddr = a; busWrData = d; busByteEn = be;
    @(negedge clk);
    busWrEn = 1'b0; busByteEn = 4'hF;
  endtask

  task automatic rd(input logic [3:0] a, input logic [31:0] exp, input string tag);
    busRdEn = 1'b1; busAddr = a;
    @(negedge clk);
    busRdEn = 1'b0;
    check(tag, busRdData, exp);
  endtask

  task automatic pulse();
    evtIn = '1;
    @(negedge clk);
    evtIn = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 irq in reset", {31'd0, irqOut}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    rd(4'h0, 32'h0, "R1 status after reset");
    rd(4'h4, 32'h1, "R1 mask after reset");
    check("R1 irq after reset", {31'd0, irqOut}, 32'd0);

    pulse();
    repeat (2) @(negedge clk);
    rd(4'h0, 32'h1, "R2 status sticky");
    check("R9 masked stays low", {31'd0, irqOut}, 32'd0);

    wr(4'h8, 32'h1, 4'hF);
    check("R9 not yet high", {31'd0, irqOut}, 32'd0);
    @(negedge clk);
    check("R9 high one cycle later", {31'd0, irqOut}, 32'd1);
    rd(4'h4, 32'h0, "R6 unmask clears");
    rd(4'h8, 32'h0, "R8 unmask reads zero");

    wr(4'h0, 32'h0, 4'hF);
    rd(4'h0, 32'h1, "R3 zero leaves bit");
    wr(4'h0, 32'h1, 4'hF);
    rd(4'h0, 32'h0, "R3 one clears bit");
    check("R9 low after clear", {31'd0, irqOut}, 32'd0);

    evtIn = '1;
    wr(4'h0, 32'h1, 4'hF);
    evtIn = '0;
    rd(4'h0, 32'h1, "R4 event beats clear");

    wr(4'h4, 32'h1, 4'hF);
    rd(4'h4, 32'h0, "R5 mask write ignored");
    check("R5 irq still high", {31'd0, irqOut}, 32'd1);

    wr(4'hC, 32'h1, 4'hF);
    rd(4'h4, 32'h1, "R7 mask cmd sets");
    rd(4'hC, 32'h0, "R8 mask cmd reads zero");
    check("R9 low after mask", {31'd0, irqOut}, 32'd0);

    wr(4'h0, 32'h1, 4'h1);
    rd(4'h0, 32'h1, "R10 partial clear ignored");
    wr(4'h1, 32'h1, 4'hF);
    rd(4'h0, 32'h1, "R10 misaligned clear ignored");
    wr(4'h8, 32'h1, 4'h7);
    rd(4'h4, 32'h1, "R10 partial unmask ignored");
    rd(4'h2, 32'h0, "R11 misaligned read zero");
    @(negedge clk);
    check("R11 idle read data zero", busRdData, 32'h0);

    for (int i = 0; i < 400; i++) begin
      evtIn     = ($urandom_range(0, 5) == 0) ? '1 : '0;
      busWrEn   = ($urandom_range(0, 2) == 0);
      busRdEn   = ($urandom_range(0, 1) == 0);
      busAddr   = 4'($urandom_range(0, 15));
      busWrData = $urandom();
      busByteEn = ($urandom_range(0, 3) == 0) ? 4'($urandom()) : 4'hF;
      @(negedge clk);
    end
    busWrEn = 1'b0; busRdEn = 1'b0; evtIn = '0; busByteEn = 4'hF;
    @(negedge clk);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

endmodule